// File: doc/BRIEF.md
# Board Control Register Bank

This block is a slave register bank that sits on a simple 32-bit read/write bus and gives software control of several board-level items. It drives an eight-LED bar and an eight-character text display. It also provides a break/reset byte, a general-purpose output byte, and a bit-banged I2C port that drives the clock and data lines toward a serial EEPROM and senses the data line coming back. A write of one special value produces a one-cycle system reset request.

Only the low 20 bits of the bus address select a register. The display can be loaded in two ways. One register takes a whole 32-bit word and shows it as eight uppercase hex digits, most significant nibble first. Eight other registers each set a single character. Reads are registered: the data appears, with a valid flag, on the clock after the read strobe.

Top module: `brd_ctl_bank`

## Requirements
- R1: After reset, the registers read as follows: LED 0x00, break 0x0A, general output 0x00, I2C output-enable 0x0, I2C output 0x3, I2C select 0x1. All eight display characters are 0x20 (space), and `scl_o`/`sda_o` are both 1.
- R2: Only address bits 19:0 decode. A read of any offset with no register returns 0, and a write to such an offset changes nothing. The switch register (0x200) and the jumper register (0x210) always read 0, and writes to them change nothing.
- R3: Offset 0x208 is read-only and returns 0x12 when parameter `BIG_ENDIAN` is 1, or 0x10 when it is 0.
- R4: A write to 0x408 stores bits 7:0 in the LED register. The register drives `led_o` and reads back zero-extended.
- R5: A write to 0x410 sets display character k (`disp_chars[8k+7:8k]`) to the uppercase ASCII hex digit of data nibble [31-4k:28-4k]. Character 0 therefore shows the most significant nibble.
- R6: A write to offset 0x418 + 8k, for k = 0..7, sets character k to data bits 7:0 and leaves the other characters unchanged. Offsets in that range that are not a multiple of 8 from 0x418 are unmapped.
- R7: A write of exactly 0x00000042 to 0x500 raises `sys_rst_req` for one cycle, on the cycle after the write. A write of any other value to that offset raises nothing.
- R8: Offsets 0x508 (break) and 0xA00 (general output) each store data bits 7:0 and read them back zero-extended.
- R9: A write to 0xB10 stores the whole 32-bit word, which reads back unchanged. Bit 1 of the stored word drives `scl_o` and bit 0 drives `sda_o`.
- R10: 0xB08 (output-enable) keeps data bits 1:0, and 0xB18 (select) keeps data bit 0. Both read back zero-extended.
- R11: A read of 0xB00 returns 0x2 with bit 0 replaced by `sda_i`, sampled in the cycle of the read strobe. A read of 0xA08 returns the stored I2C output word when select is 1, and 0 when select is 0.
- R12: `bus_rvalid` is high exactly on the cycle after a cycle with `bus_rd` high. In that cycle `bus_rdata` holds the register value as it stood before any write made in the read-strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Register address; bits 19:0 decode |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| led_o | output | 8 | LED bar drive |
| disp_chars | output | 64 | Display characters, character k in bits 8k+7:8k |
| sys_rst_req | output | 1 | One-cycle system reset request |
| scl_o | output | 1 | I2C clock drive |
| sda_o | output | 1 | I2C data drive |
| sda_i | input | 1 | I2C data line sense |

## Verification
The bench builds the block with `BIG_ENDIAN` set to 1, so the status register must read 0x12. The other parameters keep their defaults, which gives a 20-bit offset and 32-bit data. Those defaults let the bench reach several corners: address bits above bit 19 set without changing the decode, all eight character slots plus a misaligned one, and full 32-bit words through the I2C output loopback. A behavioural reference model tracks every register and is compared with all outputs on every clock. The tests cover the magic reset value next to near misses, both select settings, and both levels of `sda_i`.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;
  localparam logic [19:0] OFS_SWITCH = 20'h00200;
  localparam logic [19:0] OFS_STATUS = 20'h00208;
  localparam logic [19:0] OFS_JUMPER = 20'h00210;
  localparam logic [19:0] OFS_LED    = 20'h00408;
  localparam logic [19:0] OFS_HEXWRD = 20'h00410;
  localparam logic [19:0] OFS_CHAR0  = 20'h00418;
  localparam logic [19:0] OFS_SWRST  = 20'h00500;
  localparam logic [19:0] OFS_BRK    = 20'h00508;
  localparam logic [19:0] OFS_GPO    = 20'h00A00;
  localparam logic [19:0] OFS_GPI    = 20'h00A08;
  localparam logic [19:0] OFS_I2CIN  = 20'h00B00;
  localparam logic [19:0] OFS_I2COE  = 20'h00B08;
  localparam logic [19:0] OFS_I2COUT = 20'h00B10;
  localparam logic [19:0] OFS_I2CSEL = 20'h00B18;
  localparam logic [31:0] SWRST_KEY  = 32'h0000_0042;
  localparam logic [7:0]  CHAR_SPACE = 8'h20;
  localparam logic [7:0]  BRK_INIT   = 8'h0A;

  // Uppercase ASCII digit for one nibble.
  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'd0, n};
    else           return 8'h37 + {4'd0, n};
  endfunction

  function automatic logic [7:0] status_code(input bit big_end);
    return big_end ? 8'h12 : 8'h10;
  endfunction
endpackage

// File: rtl/brd_disp_buf.sv
module brd_disp_buf
  import brd_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    word_we,
  input  logic                    slot_we,
  input  logic [$clog2(DATA_W/4)-1:0] slot_idx,
  input  logic [DATA_W-1:0]       wdata,
  output logic [2*DATA_W-1:0]     chars
);
  localparam int NUM_CHARS = DATA_W / 4;

  for (genvar k = 0; k < NUM_CHARS; k++) begin : g_char
    logic [7:0] ch_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ch_q <= CHAR_SPACE;
      else if (word_we)
        ch_q <= nib_to_ascii(wdata[(NUM_CHARS-1-k)*4 +: 4]);
      else if (slot_we && slot_idx == k)
        ch_q <= wdata[7:0];
    end
    assign chars[8*k +: 8] = ch_q;
  end

  // R5: after a word write the first character is a hex digit
  p_hex_digit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_we |=> ((chars[7:0] >= 8'h30 && chars[7:0] <= 8'h39) ||
                 (chars[7:0] >= 8'h41 && chars[7:0] <= 8'h46)));

  // R6: a slot write to another index leaves character 0 alone
  p_slot_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_we && !word_we && slot_idx != '0) |=> $stable(chars[7:0]));
endmodule

// File: rtl/brd_i2c_port.sv
module brd_i2c_port
  import brd_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_we,
  input  logic              oe_we,
  input  logic              sel_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic [DATA_W-1:0] out_val,
  output logic [DATA_W-1:0] oe_val,
  output logic [DATA_W-1:0] sel_val,
  output logic [DATA_W-1:0] in_val,
  output logic [DATA_W-1:0] loop_val
);
  logic [DATA_W-1:0] out_q;
  logic [1:0]        oe_q;
  logic              sel_q;
  logic [1:0]        in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= DATA_W'(3);
      oe_q  <= 2'b00;
      sel_q <= 1'b1;
      in_q  <= 2'b11;
    end else begin
      if (out_we) out_q <= wdata;
      if (oe_we)  oe_q  <= wdata[1:0];
      if (sel_we) sel_q <= wdata[0];
    end
  end

  assign scl_o    = out_q[1];
  assign sda_o    = out_q[0];
  assign out_val  = out_q;
  assign oe_val   = DATA_W'(oe_q);
  assign sel_val  = DATA_W'(sel_q);
  assign in_val   = {{(DATA_W-2){1'b0}}, in_q[1], sda_i};
  assign loop_val = sel_q ? out_q : '0;

  // R9: the line drives follow the last stored output word
  p_line_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |=> (scl_o == $past(wdata[1]) && sda_o == $past(wdata[0])));
endmodule

// File: rtl/brd_ctl_bank.sv
module brd_ctl_bank
  import brd_ctl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int OFS_W      = 20,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [7:0]        led_o,
  output logic [2*DATA_W-1:0] disp_chars,
  output logic              sys_rst_req,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              sda_i
);
  localparam int NUM_CHARS = DATA_W / 4;
  localparam int IDX_W     = $clog2(NUM_CHARS);
  localparam logic [OFS_W-1:0] CHAR_LAST = OFS_W'(OFS_CHAR0) + OFS_W'(8 * (NUM_CHARS - 1));

  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] slot_rel;
  logic             hit_led, hit_word, hit_slot, hit_swrst, hit_brk, hit_gpo;
  logic             hit_oe, hit_out, hit_sel;
  logic             rst_fire;
  logic [IDX_W-1:0] slot_idx;
  logic [7:0]       led_q, brk_q, gpo_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] i2c_out, i2c_oe, i2c_sel, i2c_in, i2c_loop;

  assign ofs      = bus_addr[OFS_W-1:0];
  assign slot_rel = ofs - OFS_W'(OFS_CHAR0);
  assign slot_idx = slot_rel[IDX_W+2:3];

  always_comb begin
    hit_led   = bus_wr && ofs == OFS_W'(OFS_LED);
    hit_word  = bus_wr && ofs == OFS_W'(OFS_HEXWRD);
    hit_slot  = bus_wr && ofs >= OFS_W'(OFS_CHAR0) && ofs <= CHAR_LAST
                && slot_rel[2:0] == 3'b000;
    hit_swrst = bus_wr && ofs == OFS_W'(OFS_SWRST);
    hit_brk   = bus_wr && ofs == OFS_W'(OFS_BRK);
    hit_gpo   = bus_wr && ofs == OFS_W'(OFS_GPO);
    hit_oe    = bus_wr && ofs == OFS_W'(OFS_I2COE);
    hit_out   = bus_wr && ofs == OFS_W'(OFS_I2COUT);
    hit_sel   = bus_wr && ofs == OFS_W'(OFS_I2CSEL);
    rst_fire  = hit_swrst && bus_wdata == DATA_W'(SWRST_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q       <= 8'h00;
      brk_q       <= BRK_INIT;
      gpo_q       <= 8'h00;
      sys_rst_req <= 1'b0;
    end else begin
      if (hit_led) led_q <= bus_wdata[7:0];
      if (hit_brk) brk_q <= bus_wdata[7:0];
      if (hit_gpo) gpo_q <= bus_wdata[7:0];
      sys_rst_req <= rst_fire;
    end
  end
  assign led_o = led_q;

  brd_disp_buf #(.DATA_W(DATA_W)) u_disp (
    .clk(clk), .rst_n(rst_n), .word_we(hit_word), .slot_we(hit_slot),
    .slot_idx(slot_idx), .wdata(bus_wdata), .chars(disp_chars)
  );

  brd_i2c_port #(.DATA_W(DATA_W)) u_i2c (
    .clk(clk), .rst_n(rst_n), .out_we(hit_out), .oe_we(hit_oe), .sel_we(hit_sel),
    .wdata(bus_wdata), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
    .out_val(i2c_out), .oe_val(i2c_oe), .sel_val(i2c_sel),
    .in_val(i2c_in), .loop_val(i2c_loop)
  );

  always_comb begin
    rd_mux = '0;
    unique case (ofs)
      OFS_W'(OFS_STATUS): rd_mux = DATA_W'(status_code(BIG_ENDIAN));
      OFS_W'(OFS_LED):    rd_mux = DATA_W'(led_q);
      OFS_W'(OFS_BRK):    rd_mux = DATA_W'(brk_q);
      OFS_W'(OFS_GPO):    rd_mux = DATA_W'(gpo_q);
      OFS_W'(OFS_GPI):    rd_mux = i2c_loop;
      OFS_W'(OFS_I2CIN):  rd_mux = i2c_in;
      OFS_W'(OFS_I2COE):  rd_mux = i2c_oe;
      OFS_W'(OFS_I2COUT): rd_mux = i2c_out;
      OFS_W'(OFS_I2CSEL): rd_mux = i2c_sel;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // R7: a reset request only ever follows a write of the key value
  p_rst_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> ($past(bus_wr) && $past(bus_wdata) == DATA_W'(SWRST_KEY)));
  // R12: valid data only after a read strobe
  p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd));
  // R4: the LED pins show the byte just written
  p_led_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_led |=> led_o == $past(bus_wdata[7:0]));
  // R11: input register bit 0 carries the line sensed at the strobe
  p_sda_sense_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ofs == OFS_W'(OFS_I2CIN)) |=> bus_rdata[0] == $past(sda_i));
  // R2: the switch register reads zero
  p_switch_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ofs == OFS_W'(OFS_SWITCH)) |=> bus_rdata == '0);
endmodule

// File: tb/brd_ctl_bank_tb.sv
module brd_ctl_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  led_o;
  logic [63:0] disp_chars;
  logic        sys_rst_req;
  logic        scl_o, sda_o;
  logic        sda_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brd_ctl_bank #(.BIG_ENDIAN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .led_o(led_o), .disp_chars(disp_chars), .sys_rst_req(sys_rst_req),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
  );

  // Reference model state
  int unsigned m_led = 0, m_brk = 10, m_gpo = 0, m_oe = 0, m_out = 3, m_sel = 1;
  byte unsigned m_disp[8];
  bit m_rst = 0, m_rvalid = 0;
  int unsigned m_rdata = 0;
  string read_tag = "R12";
  string hexdig = "0123456789ABCDEF";

  function automatic int unsigned model_read(int unsigned off);
    case (off)
      'h208: return 'h12;
      'h408: return m_led;
      'h508: return m_brk;
      'hA00: return m_gpo;
      'hA08: return (m_sel != 0) ? m_out : 0;
      'hB00: return 2 + int'(sda_i);
      'hB08: return m_oe;
      'hB10: return m_out;
      'hB18: return m_sel;
      default: return 0;
    endcase
  endfunction

  task automatic model_clock();
    int unsigned off = bus_addr & 32'hFFFFF;
    m_rvalid = bus_rd;
    if (bus_rd) m_rdata = model_read(off);
    m_rst = 0;
    if (bus_wr) begin
      if (off == 'h408) m_led = bus_wdata & 'hFF;
      if (off == 'h508) m_brk = bus_wdata & 'hFF;
      if (off == 'hA00) m_gpo = bus_wdata & 'hFF;
      if (off == 'hB08) m_oe  = bus_wdata & 3;
      if (off == 'hB10) m_out = bus_wdata;
      if (off == 'hB18) m_sel = bus_wdata & 1;
      if (off == 'h500 && bus_wdata == 'h42) m_rst = 1;
      if (off == 'h410)
        for (int k = 0; k < 8; k++) m_disp[k] = byte'(hexdig[(bus_wdata >> (28 - 4*k)) & 15]);
      for (int k = 0; k < 8; k++)
        if (off == 'h418 + 8*k) m_disp[k] = bus_wdata[7:0];
    end
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[8*k +: 8] = m_disp[k];
    chk("R4", "led", 64'(led_o), 64'(m_led));
    chk("R5", "display", disp_chars, d);
    chk("R7", "reset pulse", 64'(sys_rst_req), 64'(m_rst));
    chk("R9", "scl/sda", 64'({scl_o, sda_o}), 64'(m_out & 3));
    chk("R12", "rvalid", 64'(bus_rvalid), 64'(m_rvalid));
    if (m_rvalid) chk(read_tag, "rdata", 64'(bus_rdata), 64'(m_rdata));
  endtask

  task automatic cyc(bit wr, bit rd, logic [31:0] addr, logic [31:0] data);
    bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = data;
    @(posedge clk);
    model_clock();
    #2;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    compare_all();
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    cyc(1, 0, a, d);
  endtask

  task automatic rd_exp(logic [31:0] a, logic [31:0] exp, string req);
    read_tag = req;
    cyc(0, 1, a, '0);
    chk(req, "read literal", 64'(bus_rdata), 64'(exp));
    read_tag = "R12";
  endtask

  initial begin
    for (int k = 0; k < 8; k++) m_disp[k] = 8'h20;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: reset state
    compare_all();
    chk("R1", "disp reset", disp_chars, 64'h2020202020202020);
    rd_exp(32'h408, 32'h0, "R1");
    rd_exp(32'h508, 32'h0A, "R1");
    rd_exp(32'hA00, 32'h0, "R1");
    rd_exp(32'hB08, 32'h0, "R1");
    rd_exp(32'hB10, 32'h3, "R1");
    rd_exp(32'hB18, 32'h1, "R1");
    chk("R1", "lines reset", 64'({scl_o, sda_o}), 64'h3);
    // R3: status
    rd_exp(32'h208, 32'h12, "R3");
    wr(32'h208, 32'hFFFF_FFFF);
    rd_exp(32'h208, 32'h12, "R3");
    // R4: LED with upper address bits set
    wr(32'hFFF0_0408, 32'h1234_56A5);
    chk("R4", "led pins", 64'(led_o), 64'hA5);
    rd_exp(32'h408, 32'hA5, "R4");
    // R2: switch, jumper, unmapped
    wr(32'h200, 32'hFFFF_FFFF);
    wr(32'h210, 32'h1234_5678);
    wr(32'h300, 32'hDEAD_BEEF);
    rd_exp(32'h200, 32'h0, "R2");
    rd_exp(32'h210, 32'h0, "R2");
    rd_exp(32'h300, 32'h0, "R2");
    rd_exp(32'h410, 32'h0, "R2");
    rd_exp(32'h0010_0408, 32'hA5, "R2");
    // R5: hex word writes
    wr(32'h410, 32'hDEAD_BEEF);
    chk("R5", "char0 D", 64'(disp_chars[7:0]), 64'h44);
    chk("R5", "char7 F", 64'(disp_chars[63:56]), 64'h46);
    wr(32'h410, 32'h0123_4567);
    chk("R5", "digits", disp_chars, 64'h3736353433323130);
    wr(32'h410, 32'h89AB_CDEF);
    // R6: per-character writes, misaligned slot ignored
    wr(32'h430, 32'hFFFF_FF5A);
    chk("R6", "slot3", 64'(disp_chars[31:24]), 64'h5A);
    wr(32'h418, 32'h0000_0061);
    wr(32'h450, 32'h0000_007A);
    chk("R6", "slot7", 64'(disp_chars[63:56]), 64'h7A);
    wr(32'h41C, 32'h0000_0021);
    wr(32'h458, 32'h0000_0021);
    chk("R6", "misaligned ignored", 64'(disp_chars[15:8]), 64'h39);
    // R7: reset key
    wr(32'h500, 32'h43);
    wr(32'h500, 32'h142);
    wr(32'h500, 32'h42);
    chk("R7", "pulse high", 64'(sys_rst_req), 64'h1);
    cyc(0, 0, 32'h0, 32'h0);
    chk("R7", "pulse one cycle", 64'(sys_rst_req), 64'h0);
    // R8: break and general output
    wr(32'h508, 32'hFFFF_FF3C);
    wr(32'hA00, 32'h0000_01C3);
    rd_exp(32'h508, 32'h3C, "R8");
    rd_exp(32'hA00, 32'hC3, "R8");
    // R9: I2C output
    wr(32'hB10, 32'hFFFF_FFF2);
    chk("R9", "scl1 sda0", 64'({scl_o, sda_o}), 64'h2);
    rd_exp(32'hB10, 32'hFFFF_FFF2, "R9");
    wr(32'hB10, 32'h0000_0001);
    chk("R9", "scl0 sda1", 64'({scl_o, sda_o}), 64'h1);
    // R10: output-enable and select widths
    wr(32'hB08, 32'hFFFF_FFFF);
    rd_exp(32'hB08, 32'h3, "R10");
    wr(32'hB18, 32'hFFFF_FFFE);
    rd_exp(32'hB18, 32'h0, "R10");
    // R11: loopback and live sense
    rd_exp(32'hA08, 32'h0, "R11");
    wr(32'hB18, 32'h1);
    rd_exp(32'hA08, 32'h1, "R11");
    wr(32'hB10, 32'hCAFE_0003);
    rd_exp(32'hA08, 32'hCAFE_0003, "R11");
    sda_i = 1'b0;
    rd_exp(32'hB00, 32'h2, "R11");
    sda_i = 1'b1;
    rd_exp(32'hB00, 32'h3, "R11");
    // R12: read before a same-cycle write sees the old value
    read_tag = "R12";
    cyc(1, 1, 32'h408, 32'h77);
    chk("R12", "old value", 64'(bus_rdata), 64'hA5);
    rd_exp(32'h408, 32'h77, "R12");
    cyc(0, 0, 32'h0, 32'h0);
    chk("R12", "rvalid drops", 64'(bus_rvalid), 64'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule